// File: doc/BRIEF.md
# Asymmetric Decode Group Steering

This block sits after instruction length marking. Each cycle it looks at a window of three instructions in program order and decides which of them go to the decoders this cycle. There are three decoder slots. Slot 0 is a full decoder that takes an instruction of up to four micro-ops. Slots 1 and 2 are partial decoders that take an instruction only if it yields a single micro-op.

Each window entry has three inputs: a valid bit, its raw micro-op count and a fusible flag. The fusible flag marks a memory-source or memory-destination instruction whose two micro-ops travel as one fused micro-op. A fusible entry with a count of two therefore counts as one micro-op, and a partial slot can take it. For every slot that receives such an entry, the block asserts a per-slot fuse select. That select steers the decoder to its own extra translation table.

The block drives, all in the same cycle, the per-slot valid bits, the number of entries consumed from the head of the window, a request to the microcode sequencer for long instructions, and a hold flag. The hold flag tells the fetch side that valid entries remain unconsumed. A downstream stall freezes the group: nothing is steered and the window stays where it is. The steering is purely combinational. Clock and reset serve only the embedded property checks.

Each window entry is sorted into one of five named classes. NONE is an invalid entry. SINGLE has a count of 0 or 1. FUSED has a count of 2 with the fusible flag set. MULTI has a count of up to four. LONG has a count above four. Slot filling walks the classes in order and stops at the first class a slot cannot take.

Top module: `dec_group_steer`

## Requirements
- R1: When not stalled and window entry 0 is valid with an effective count from 1 to 4, slot 0 is filled. A raw count of 0 is treated as 1.
- R2: Slot k (k = 1, 2) is filled only by window entry k. That entry must have a raw count of 0 or 1, or a raw count of 2 with the fusible flag set.
- R3: Bit k of `slot_fuse_o` is 1 exactly when slot k is filled by an entry with raw count 2 and the fusible flag set. A fusible entry with a count of 3 or more gets no reduction and cannot enter a partial slot.
- R4: Slots fill strictly in order. Slot k is filled only if slot k-1 is filled. The first invalid or ineligible entry ends the group, even if later entries would fit.
- R5: An entry at position 0 with a raw count above 4 fills slot 0 alone, raises `ms_req_o` and consumes exactly one entry. A long entry at position 1 or 2 is not taken.
- R6: `take_cnt_o` equals the number of filled slots (0 to 3) in the same cycle as `slot_vld_o`.
- R7: While `stall_i` is 1, `slot_vld_o`, `slot_fuse_o`, `take_cnt_o` and `ms_req_o` are all 0.
- R8: `hold_o` is 1 exactly when some valid window entry is not consumed this cycle.
- R9: A stream of count-2 fusible instructions drains three per cycle; the same stream without the fusible flag drains one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rst_n | input | 1 | Active-low reset, disables the property checks |
| win_vld_i | input | 3 | Valid bit per window entry, bit 0 oldest |
| win_uops_i | input | 9 | Raw micro-op count per entry, 3 bits each, entry k at bits [3k+2:3k] |
| win_fus_i | input | 3 | Fusible flag per window entry |
| stall_i | input | 1 | Downstream stall, freezes the group |
| slot_vld_o | output | 3 | Slot k receives window entry k |
| slot_fuse_o | output | 3 | Slot k uses the fused-form translation table |
| take_cnt_o | output | 2 | Entries consumed from the window head |
| ms_req_o | output | 1 | Slot 0 holds an instruction needing the microcode sequencer |
| hold_o | output | 1 | Valid entries remain unconsumed |

## Verification
The block has no stored state, so any wrong internal decision shows up at the ports in the same cycle. A wrong entry class shows as a missing or extra slot valid, a wrong fuse select, or a wrong count. A broken chain between slots shows as a gap in `slot_vld_o` or a `hold_o` that disagrees with the count. The bench rebuilds each cycle's expected group from the raw window inputs and compares every output on every clock. It also replays fused and unfused streams and counts the cycles each one takes to drain.

// File: rtl/steer_pkg.sv
package steer_pkg;

    // Class of one window entry as seen by the steering walk
    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_SINGLE = 3'd1,
        CLS_FUSED  = 3'd2,
        CLS_MULTI  = 3'd3,
        CLS_LONG   = 3'd4
    } ucls_e;

endpackage

// File: rtl/uop_classify.sv
module uop_classify
    import steer_pkg::*;
#(
    parameter int UOP_W    = 3,
    parameter int FULL_MAX = 4
) (
    input  logic             vld_i,
    input  logic [UOP_W-1:0] uops_i,
    input  logic             fus_i,
    output ucls_e            cls_o
);

    always_comb begin
        if (!vld_i) begin
            cls_o = CLS_NONE;
        end else if (uops_i <= UOP_W'(1)) begin
            cls_o = CLS_SINGLE;
        end else if (uops_i == UOP_W'(2) && fus_i) begin
            cls_o = CLS_FUSED;
        end else if (int'(uops_i) <= FULL_MAX) begin
            cls_o = CLS_MULTI;
        end else begin
            cls_o = CLS_LONG;
        end
    end

endmodule

// File: rtl/steer_chain.sv
module steer_chain
    import steer_pkg::*;
#(
    parameter int SLOTS = 3,
    parameter int CNT_W = 2
) (
    input  ucls_e              cls_i [SLOTS],
    input  logic               stall_i,
    output logic [SLOTS-1:0]   take_o,
    output logic [SLOTS-1:0]   fuse_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               ms_o,
    output logic               hold_o
);

    logic [SLOTS-1:0] take;
    logic [SLOTS-1:0] open;
    logic             take0;
    logic             open0;
    logic             ms0;

    // Full decoder slot: any valid class, long ones close the group
    always_comb begin
        take0 = 1'b0;
        open0 = 1'b0;
        ms0   = 1'b0;
        if (!stall_i) begin
            unique case (cls_i[0])
                CLS_SINGLE, CLS_FUSED, CLS_MULTI: begin
                    take0 = 1'b1;
                    open0 = 1'b1;
                end
                CLS_LONG: begin
                    take0 = 1'b1;
                    ms0   = 1'b1;
                end
                default: begin
                    take0 = 1'b0;
                end
            endcase
        end
    end

    assign take[0] = take0;
    assign open[0] = open0;

    // Partial decoder slots: single micro-op classes only, in order
    for (genvar k = 1; k < SLOTS; k++) begin : g_part
        logic part_ok;
        always_comb begin
            unique case (cls_i[k])
                CLS_SINGLE, CLS_FUSED: part_ok = 1'b1;
                default:               part_ok = 1'b0;
            endcase
        end
        assign take[k] = open[k-1] & part_ok;
        assign open[k] = take[k];
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_fuse
        assign fuse_o[k] = take[k] & (cls_i[k] == CLS_FUSED);
    end

    always_comb begin
        hold_o = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            if (cls_i[k] != CLS_NONE && !take[k]) hold_o = 1'b1;
        end
    end

    assign cnt_o  = CNT_W'($countones(take));
    assign take_o = take;
    assign ms_o   = ms0;

endmodule

// File: rtl/dec_group_steer.sv
module dec_group_steer
    import steer_pkg::*;
#(
    parameter int SLOTS    = 3,
    parameter int UOP_W    = 3,
    parameter int FULL_MAX = 4,
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS-1:0]       win_vld_i,
    input  logic [SLOTS*UOP_W-1:0] win_uops_i,
    input  logic [SLOTS-1:0]       win_fus_i,
    input  logic                   stall_i,
    output logic [SLOTS-1:0]       slot_vld_o,
    output logic [SLOTS-1:0]       slot_fuse_o,
    output logic [CNT_W-1:0]       take_cnt_o,
    output logic                   ms_req_o,
    output logic                   hold_o
);

    ucls_e cls [SLOTS];

    for (genvar k = 0; k < SLOTS; k++) begin : g_cls
        uop_classify #(
            .UOP_W    (UOP_W),
            .FULL_MAX (FULL_MAX)
        ) u_cls (
            .vld_i  (win_vld_i[k]),
            .uops_i (win_uops_i[k*UOP_W +: UOP_W]),
            .fus_i  (win_fus_i[k]),
            .cls_o  (cls[k])
        );
    end

    steer_chain #(
        .SLOTS (SLOTS),
        .CNT_W (CNT_W)
    ) u_chain (
        .cls_i   (cls),
        .stall_i (stall_i),
        .take_o  (slot_vld_o),
        .fuse_o  (slot_fuse_o),
        .cnt_o   (take_cnt_o),
        .ms_o    (ms_req_o),
        .hold_o  (hold_o)
    );

    // R7
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> (slot_vld_o == '0 && slot_fuse_o == '0 && take_cnt_o == '0
                     && !ms_req_o && hold_o == (|win_vld_i)));

    // R4
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld_o & (slot_vld_o + 1'b1)) == '0);

    // R5
    long_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_req_o |-> (slot_vld_o == SLOTS'(1) && int'(win_uops_i[UOP_W-1:0]) > FULL_MAX));

    // R1
    full_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && win_vld_i[0]) |-> slot_vld_o[0]);

    // R3
    fuse_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_fuse_o & ~(slot_vld_o & win_fus_i)) == '0);

    for (genvar k = 1; k < SLOTS; k++) begin : g_part_chk
        // R2
        partial_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld_o[k] |-> (win_uops_i[k*UOP_W +: UOP_W] <= UOP_W'(1)
                || (win_uops_i[k*UOP_W +: UOP_W] == UOP_W'(2) && win_fus_i[k])));
    end

endmodule

// File: tb/sim_dec_group_steer.sv
`timescale 1ns/1ps
module sim_dec_group_steer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] win_vld_i = '0;
    logic [8:0] win_uops_i = '0;
    logic [2:0] win_fus_i = '0;
    logic       stall_i = 1'b0;
    logic [2:0] slot_vld_o;
    logic [2:0] slot_fuse_o;
    logic [1:0] take_cnt_o;
    logic       ms_req_o;
    logic       hold_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dec_group_steer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_vld_i   (win_vld_i),
        .win_uops_i  (win_uops_i),
        .win_fus_i   (win_fus_i),
        .stall_i     (stall_i),
        .slot_vld_o  (slot_vld_o),
        .slot_fuse_o (slot_fuse_o),
        .take_cnt_o  (take_cnt_o),
        .ms_req_o    (ms_req_o),
        .hold_o      (hold_o)
    );

    // Behavioural reference: {slot_vld, slot_fuse, cnt, ms, hold}
    function automatic logic [9:0] ref_out(input logic [2:0] v, input logic [8:0] u,
                                           input logic [2:0] f, input logic st);
        int n = 0;
        logic [2:0] sv = '0;
        logic [2:0] fz = '0;
        logic ms = 1'b0;
        logic hd = 1'b0;
        bit stop = 1'b0;
        if (!st) begin
            for (int i = 0; i < 3; i++) begin
                int cnt;
                int eff;
                bit fu;
                if (stop || !v[i]) begin
                    stop = 1'b1;
                end else begin
                    cnt = int'(u[i*3 +: 3]);
                    fu  = (cnt == 2) && f[i];
                    eff = fu ? 1 : ((cnt == 0) ? 1 : cnt);
                    if (i == 0) begin
                        sv[0] = 1'b1; fz[0] = fu; n = 1;
                        if (eff > 4) begin ms = 1'b1; stop = 1'b1; end
                    end else if (eff == 1) begin
                        sv[i] = 1'b1; fz[i] = fu; n++;
                    end else begin
                        stop = 1'b1;
                    end
                end
            end
        end
        for (int j = 0; j < 3; j++) if (v[j] && j >= n) hd = 1'b1;
        return {sv, fz, 2'(n), ms, hd};
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive one window, compare on the following low phase
    task automatic apply(input string tag, input logic [2:0] v, input int a, input int b,
                         input int c, input logic [2:0] f, input logic st, output int took);
        logic [9:0] exp;
        @(posedge clk);
        #1;
        win_vld_i  = v;
        win_uops_i = {3'(c), 3'(b), 3'(a)};
        win_fus_i  = f;
        stall_i    = st;
        exp = ref_out(v, {3'(c), 3'(b), 3'(a)}, f, st);
        @(negedge clk);
        check(tag, {slot_vld_o, slot_fuse_o, take_cnt_o, ms_req_o, hold_o}, exp);
        took = int'(exp[3:2]);
    endtask

    task automatic drain(input string tag, input bit fus, input int len, input int want);
        int uq[$];
        int cycles = 0;
        int took;
        for (int i = 0; i < len; i++) uq.push_back(2);
        while (uq.size() > 0 && cycles < 50) begin
            logic [2:0] v = '0;
            int u [3] = '{0, 0, 0};
            for (int k = 0; k < 3; k++) begin
                if (k < uq.size()) begin v[k] = 1'b1; u[k] = uq[k]; end
            end
            apply(tag, v, u[0], u[1], u[2], fus ? 3'b111 : 3'b000, 1'b0, took);
            for (int k = 0; k < took; k++) void'(uq.pop_front());
            cycles++;
        end
        n_chk++;
        if (cycles != want) begin
            n_bad++;
            $display("FAIL %s: actual %0d cycles expected %0d", tag, cycles, want);
        end
    endtask

    initial begin
        #800000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("reset R6", {slot_vld_o, slot_fuse_o, take_cnt_o, ms_req_o, hold_o}, 10'b0);
        rst_n = 1'b1;
        apply("R1 R6 all single",      3'b111, 1, 1, 1, 3'b000, 1'b0, t);
        apply("R1 four in full slot",  3'b111, 4, 1, 1, 3'b000, 1'b0, t);
        apply("R1 zero count",         3'b111, 0, 0, 1, 3'b000, 1'b0, t);
        apply("R2 unfused two blocks", 3'b111, 1, 2, 1, 3'b000, 1'b0, t);
        apply("R2 multi then singles", 3'b111, 2, 1, 1, 3'b000, 1'b0, t);
        apply("R3 fused partials",     3'b111, 1, 2, 2, 3'b110, 1'b0, t);
        apply("R3 fused three no",     3'b111, 2, 3, 1, 3'b011, 1'b0, t);
        apply("R3 fused head",         3'b111, 2, 2, 4, 3'b011, 1'b0, t);
        apply("R5 long head",          3'b111, 5, 1, 1, 3'b000, 1'b0, t);
        apply("R5 long tail",          3'b111, 1, 1, 7, 3'b000, 1'b0, t);
        apply("R4 head invalid",       3'b110, 1, 1, 1, 3'b000, 1'b0, t);
        apply("R4 R8 gap",             3'b101, 1, 1, 1, 3'b000, 1'b0, t);
        apply("R8 two valid",          3'b011, 1, 1, 1, 3'b000, 1'b0, t);
        apply("R8 empty",              3'b000, 1, 1, 1, 3'b000, 1'b0, t);
        apply("R7 stall with work",    3'b111, 1, 2, 2, 3'b110, 1'b1, t);
        apply("R7 stall long",         3'b001, 6, 0, 0, 3'b000, 1'b1, t);
        apply("R7 stall empty",        3'b000, 1, 1, 1, 3'b000, 1'b1, t);
        apply("R7 release",            3'b111, 1, 2, 2, 3'b110, 1'b0, t);
        drain("R9 fused stream",   1'b1, 9, 3);
        drain("R9 unfused stream", 1'b0, 9, 9);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule